// File: doc/BRIEF.md
# Vector Synchronization Request Arbiter

This block answers synchronization requests that the scalar side issues to the vector unit. A request is either an exception sync or a memory-activity check. An exception sync completes only when no earlier vector instruction can still raise an exception. It faults if an unreported exception is present or shows up while the request waits. A memory-activity check waits only until vector and scalar memory traffic has stopped. It never faults, and it does not wait for instructions to finish.

The datapath supplies the state the arbiter needs:
- two level flags for unreported disabled-class and memory-management exceptions;
- one "exception still possible" bit per in-flight instruction slot;
- a memory-busy flag.

A request is taken with a valid/ready handshake. The arbiter then holds off any further request until its answer has been taken by the requester. The answer is a 2-bit code with a 32-bit word: a fixed token on completion, zero on a fault.

Top module: `sync_arbiter`

## Requirements
- R1: After reset, rsp_valid_o is 0, req_ready_o is 1, and rsp_code_o and rsp_data_o are 0.
- R2: An exception sync (req_kind_i = 0) accepted while pend_dis_i is 1 produces a response with rsp_code_o = 2'b01 (disabled fault) in the cycle after acceptance.
- R3: When pend_dis_i and pend_mmf_i are both 1 at resolution, an exception sync reports 2'b01, never 2'b10.
- R4: An exception sync resolved with only pend_mmf_i set reports 2'b10 (memory-management fault).
- R5: An exception sync with no pending exception and any exc_poss_i bit set gives no response.
- R6: If an exception flag rises while an exception sync waits, the sync faults with the prioritised code one cycle after the flag is sampled.
- R7: An exception sync with no pending exception and all exc_poss_i bits clear completes with rsp_code_o = 2'b00 and rsp_data_o = DONE_WORD.
- R8: Every fault response carries rsp_data_o = 0.
- R9: A memory-activity check (req_kind_i = 1) ignores both exception flags and exc_poss_i. It waits while mem_busy_i is 1 and completes with code 2'b00 once mem_busy_i is sampled 0.
- R10: From acceptance until the response handshake (rsp_valid_o and rsp_ready_i), req_ready_o is 0. A response not yet taken keeps its code and data stable. After the handshake, rsp_valid_o is 0 and req_ready_o is 1.
- R11: An exception sync does not depend on mem_busy_i: it completes with mem_busy_i held at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request offered |
| req_kind_i | input | 1 | 0 exception sync, 1 memory-activity check |
| req_ready_o | output | 1 | Request can be accepted |
| pend_dis_i | input | 1 | Unreported exception that raises a disabled fault |
| pend_mmf_i | input | 1 | Unreported memory-management exception |
| exc_poss_i | input | SLOTS | Per in-flight slot: exception still possible |
| mem_busy_i | input | 1 | Vector or scalar memory operations active |
| rsp_valid_o | output | 1 | Response available |
| rsp_ready_i | input | 1 | Requester takes the response |
| rsp_code_o | output | 2 | 00 complete, 01 disabled fault, 10 memory-management fault |
| rsp_data_o | output | DATA_W | Token on completion, zero on fault |

## Verification
The directed cases are these:
- a fault already pending at acceptance, with each flag alone and with both flags, which separates the immediate fault from the priority rule;
- a memory check with every exception input set, which shows it ignores exception state;
- an exception sync with memory busy, which shows it ignores memory traffic.

Random trials start with random slot bits, flags and memory activity. While a request waits, slot bits clear at random and exception flags sometimes rise. These trials tell an early fault apart from a normal completion after the last slot clears. They also stall the response handshake at random, and they offer stray requests while one is outstanding to confirm that none is accepted.

// File: rtl/sync_arb_pkg.sv
`timescale 1ns/1ps
package sync_arb_pkg;
  typedef enum logic [1:0] {
    RSP_DONE = 2'b00,
    RSP_DIS  = 2'b01,
    RSP_MMF  = 2'b10
  } rsp_code_e;

  typedef enum logic {
    KIND_EXC = 1'b0,
    KIND_MEM = 1'b1
  } req_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_RESP
  } arb_state_e;
endpackage

// File: rtl/sync_resolve.sv
`timescale 1ns/1ps
module sync_resolve
  import sync_arb_pkg::*;
#(
  parameter int SLOTS = 8
) (
  input  req_kind_e        kind_i,
  input  logic             pend_dis_i,
  input  logic             pend_mmf_i,
  input  logic [SLOTS-1:0] exc_poss_i,
  input  logic             mem_busy_i,
  output logic             done_o,
  output rsp_code_e        code_o
);
  localparam int LVLS = $clog2(SLOTS) + 1;
  localparam int PAD  = 1 << (LVLS - 1);

  // balanced OR tree over the slot bits
  logic [PAD-1:0] lvl [LVLS];
  assign lvl[0] = {{(PAD-SLOTS){1'b0}}, exc_poss_i};

  for (genvar l = 1; l < LVLS; l++) begin : g_lvl
    for (genvar n = 0; n < PAD; n++) begin : g_node
      if (n < (PAD >> l)) begin : g_or
        assign lvl[l][n] = lvl[l-1][2*n] | lvl[l-1][2*n+1];
      end else begin : g_zero
        assign lvl[l][n] = 1'b0;
      end
    end
  end

  logic any_poss;
  assign any_poss = lvl[LVLS-1][0];

  always_comb begin
    done_o = 1'b0;
    code_o = RSP_DONE;
    if (kind_i == KIND_MEM) begin
      done_o = !mem_busy_i;
    end else if (pend_dis_i) begin
      // disabled fault outranks memory-management fault
      done_o = 1'b1;
      code_o = RSP_DIS;
    end else if (pend_mmf_i) begin
      done_o = 1'b1;
      code_o = RSP_MMF;
    end else begin
      done_o = !any_poss;
    end
  end
endmodule

// File: rtl/sync_ctrl.sv
`timescale 1ns/1ps
module sync_ctrl
  import sync_arb_pkg::*;
#(
  parameter int          DATA_W    = 32,
  parameter logic [31:0] DONE_WORD = 32'h5EC0_0001
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  req_kind_e         req_kind_i,
  input  logic              done_i,
  input  rsp_code_e         code_i,
  input  logic              rsp_ready_i,
  output logic              req_ready_o,
  output req_kind_e         kind_o,
  output logic              rsp_valid_o,
  output rsp_code_e         rsp_code_o,
  output logic [DATA_W-1:0] rsp_data_o
);
  arb_state_e        st_q, st_d;
  req_kind_e         kind_q, kind_d;
  rsp_code_e         code_q, code_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              resolve;

  assign req_ready_o = (st_q == ST_IDLE);
  assign rsp_valid_o = (st_q == ST_RESP);
  assign kind_o      = kind_q;
  assign rsp_code_o  = code_q;
  assign rsp_data_o  = data_q;

  assign resolve = done_i && ((st_q == ST_WAIT) || (st_q == ST_IDLE && req_valid_i));

  always_comb begin
    st_d   = st_q;
    kind_d = kind_q;
    code_d = code_q;
    data_d = data_q;
    case (st_q)
      ST_IDLE: if (req_valid_i) begin
        kind_d = req_kind_i;
        st_d   = ST_WAIT;
      end
      ST_RESP: if (rsp_ready_i) st_d = ST_IDLE;
      default: ;
    endcase
    if (resolve) begin
      st_d   = ST_RESP;
      code_d = code_i;
      data_d = (code_i == RSP_DONE) ? DONE_WORD[DATA_W-1:0] : '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      kind_q <= KIND_EXC;
      code_q <= RSP_DONE;
      data_q <= '0;
    end else begin
      st_q   <= st_d;
      kind_q <= kind_d;
      code_q <= code_d;
      data_q <= data_d;
    end
  end
endmodule

// File: rtl/sync_arbiter.sv
`timescale 1ns/1ps
module sync_arbiter
  import sync_arb_pkg::*;
#(
  parameter int          SLOTS     = 8,
  parameter int          DATA_W    = 32,
  parameter logic [31:0] DONE_WORD = 32'h5EC0_0001
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_kind_i,
  output logic              req_ready_o,
  input  logic              pend_dis_i,
  input  logic              pend_mmf_i,
  input  logic [SLOTS-1:0]  exc_poss_i,
  input  logic              mem_busy_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic [1:0]        rsp_code_o,
  output logic [DATA_W-1:0] rsp_data_o
);
  req_kind_e kind_q, eval_kind;
  rsp_code_e res_code, out_code;
  logic      res_done;

  // in idle the incoming kind is resolved in its accept cycle
  assign eval_kind = req_ready_o ? req_kind_e'(req_kind_i) : kind_q;

  sync_resolve #(.SLOTS(SLOTS)) u_resolve (
    .kind_i     (eval_kind),
    .pend_dis_i (pend_dis_i),
    .pend_mmf_i (pend_mmf_i),
    .exc_poss_i (exc_poss_i),
    .mem_busy_i (mem_busy_i),
    .done_o     (res_done),
    .code_o     (res_code)
  );

  sync_ctrl #(.DATA_W(DATA_W), .DONE_WORD(DONE_WORD)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_kind_i  (req_kind_e'(req_kind_i)),
    .done_i      (res_done),
    .code_i      (res_code),
    .rsp_ready_i (rsp_ready_i),
    .req_ready_o (req_ready_o),
    .kind_o      (kind_q),
    .rsp_valid_o (rsp_valid_o),
    .rsp_code_o  (out_code),
    .rsp_data_o  (rsp_data_o)
  );

  assign rsp_code_o = out_code;
endmodule

// File: rtl/sync_arbiter_chk.sv
`timescale 1ns/1ps
module sync_arbiter_chk #(
  parameter int SLOTS  = 8,
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_kind_i,
  input logic              req_ready_o,
  input logic              pend_dis_i,
  input logic              pend_mmf_i,
  input logic [SLOTS-1:0]  exc_poss_i,
  input logic              mem_busy_i,
  input logic              rsp_valid_o,
  input logic              rsp_ready_i,
  input logic [1:0]        rsp_code_o,
  input logic [DATA_W-1:0] rsp_data_o,
  input logic              kind_q
);
  logic waiting;
  assign waiting = !req_ready_o && !rsp_valid_o;

  a_r2_immediate_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o && !req_kind_i && pend_dis_i
    |=> rsp_valid_o && rsp_code_o == 2'b01);

  a_r4_mmf_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o && !req_kind_i && !pend_dis_i && pend_mmf_i
    |=> rsp_valid_o && rsp_code_o == 2'b10);

  a_r5_hold_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    waiting && !kind_q && (|exc_poss_i) && !pend_dis_i && !pend_mmf_i
    |=> !rsp_valid_o);

  a_r8_fault_no_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_code_o != 2'b00 |-> rsp_data_o == '0);

  a_r9_mem_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    waiting && kind_q && mem_busy_i |=> !rsp_valid_o);

  a_r9_mem_no_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && kind_q |-> rsp_code_o == 2'b00);

  a_r10_no_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !req_ready_o);

  a_r10_rsp_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i
    |=> rsp_valid_o && $stable(rsp_code_o) && $stable(rsp_data_o));

  a_r10_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_ready_i |=> !rsp_valid_o && req_ready_o);
endmodule

bind sync_arbiter sync_arbiter_chk #(.SLOTS(SLOTS), .DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_kind_i  (req_kind_i),
  .req_ready_o (req_ready_o),
  .pend_dis_i  (pend_dis_i),
  .pend_mmf_i  (pend_mmf_i),
  .exc_poss_i  (exc_poss_i),
  .mem_busy_i  (mem_busy_i),
  .rsp_valid_o (rsp_valid_o),
  .rsp_ready_i (rsp_ready_i),
  .rsp_code_o  (rsp_code_o),
  .rsp_data_o  (rsp_data_o),
  .kind_q      (kind_q)
);

// File: tb/tb_sync_arbiter.sv
`timescale 1ns/1ps
module tb_sync_arbiter;
  localparam int          SLOTS  = 8;
  localparam int          DATA_W = 32;
  localparam logic [31:0] TOKEN  = 32'h5EC0_0001;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0, req_kind = 1'b0;
  logic             pend_dis = 1'b0, pend_mmf = 1'b0, mem_busy = 1'b0;
  logic [SLOTS-1:0] poss = '0;
  logic             rsp_ready = 1'b0;
  logic             req_ready, rsp_valid;
  logic [1:0]       rsp_code;
  logic [DATA_W-1:0] rsp_data;

  int  checks = 0, errors = 0;
  bit  finished = 1'b0;

  always #4 clk = ~clk;

  sync_arbiter #(.SLOTS(SLOTS), .DATA_W(DATA_W), .DONE_WORD(TOKEN)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_kind_i(req_kind), .req_ready_o(req_ready),
    .pend_dis_i(pend_dis), .pend_mmf_i(pend_mmf), .exc_poss_i(poss),
    .mem_busy_i(mem_busy),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready),
    .rsp_code_o(rsp_code), .rsp_data_o(rsp_data)
  );

  // returns {resolved, code}
  function automatic logic [2:0] model(input logic kind, dis, mmf,
                                       input logic [SLOTS-1:0] p, input logic busy);
    if (kind)     return {!busy, 2'b00};
    if (dis)      return {1'b1, 2'b01};
    if (mmf)      return {1'b1, 2'b10};
    return {p == '0, 2'b00};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic trial(input logic kind, dis, mmf, input logic [SLOTS-1:0] p,
                       input logic busy, input bit evolve, input int hold,
                       input string tag_in);
    logic [2:0] e;
    int    cyc;
    string tag;
    logic [1:0] code0;
    logic [31:0] data0;
    @(negedge clk);
    req_valid = 1'b1; req_kind = kind;
    pend_dis = dis; pend_mmf = mmf; poss = p; mem_busy = busy;
    @(posedge clk);
    e = model(kind, pend_dis, pend_mmf, poss, mem_busy);
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 0;
    while (!e[2]) begin
      chk(rsp_valid == 1'b0, kind ? "R9 wait" : "R5 wait", 32'(rsp_valid), 0);
      chk(req_ready == 1'b0, "R10 no accept", 32'(req_ready), 0);
      if (cyc > 30) begin
        poss = '0; mem_busy = 1'b0;
      end else if (evolve) begin
        poss = poss & SLOTS'($urandom);
        if ($urandom % 16 == 0) pend_dis = 1'b1;
        if ($urandom % 16 == 0) pend_mmf = 1'b1;
        mem_busy = ($urandom % 3) != 0;
      end
      req_valid = 1'($urandom);
      req_kind  = 1'($urandom);
      @(posedge clk);
      e = model(kind, pend_dis, pend_mmf, poss, mem_busy);
      @(negedge clk);
      cyc++;
    end
    req_valid = 1'b0;
    if (tag_in != "")       tag = tag_in;
    else if (kind)          tag = "R9";
    else if (cyc > 0 && e[1:0] != 2'b00) tag = "R6";
    else if (e[1:0] == 2'b01) tag = pend_mmf ? "R3" : "R2";
    else if (e[1:0] == 2'b10) tag = "R4";
    else                    tag = "R7";
    chk(rsp_valid == 1'b1, {tag, " valid"}, 32'(rsp_valid), 1);
    chk(rsp_code == e[1:0], {tag, " code"}, 32'(rsp_code), 32'(e[1:0]));
    chk(rsp_data == ((e[1:0] == 2'b00) ? TOKEN : 32'h0),
        (e[1:0] == 2'b00) ? {tag, " data"} : "R8 data",
        rsp_data, (e[1:0] == 2'b00) ? TOKEN : 32'h0);
    code0 = rsp_code; data0 = rsp_data;
    for (int h = 0; h < hold; h++) begin
      pend_dis = 1'($urandom); pend_mmf = 1'($urandom); poss = SLOTS'($urandom);
      @(negedge clk);
      chk(rsp_valid && rsp_code == code0 && rsp_data == data0, "R10 stable",
          rsp_data, data0);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(rsp_valid == 1'b0 && req_ready == 1'b1, "R10 release",
        {30'h0, rsp_valid, req_ready}, 32'h1);
    pend_dis = 1'b0; pend_mmf = 1'b0; poss = '0; mem_busy = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(rsp_valid == 1'b0, "R1 valid", 32'(rsp_valid), 0);
    chk(req_ready == 1'b1, "R1 ready", 32'(req_ready), 1);
    chk(rsp_code == 2'b00 && rsp_data == '0, "R1 outputs", rsp_data, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rsp_valid == 1'b0 && req_ready == 1'b1, "R1 after release",
        {30'h0, rsp_valid, req_ready}, 32'h1);

    // directed corners
    trial(1'b0, 1'b1, 1'b0, 8'hFF, 1'b0, 1'b0, 0, "R2");
    trial(1'b0, 1'b1, 1'b1, 8'h00, 1'b1, 1'b0, 2, "R3");
    trial(1'b0, 1'b0, 1'b1, 8'h3C, 1'b0, 1'b0, 1, "R4");
    trial(1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 0, "R7");
    trial(1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 0, "R11");
    trial(1'b1, 1'b1, 1'b1, 8'hFF, 1'b0, 1'b0, 1, "R9");
    trial(1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 0, "R9");
    trial(1'b0, 1'b0, 1'b0, 8'h81, 1'b0, 1'b1, 3, "");

    for (int t = 0; t < 300; t++) begin
      trial(($urandom % 4) == 0, ($urandom % 8) == 0, ($urandom % 8) == 0,
            SLOTS'($urandom), 1'($urandom), 1'b1, $urandom % 3, "");
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R10 watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule